// File: doc/BRIEF.md
# Pulse-Swallow RF Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer. It runs directly on the RF clock and emits one single-cycle pulse every `ratio` RF clocks, where `ratio` is an 18-bit value. Internally a two-modulus prescaler (divide by 31 or by 32) is steered by a 5-bit swallow counter and counted by a 13-bit main counter. The mix of 31-cycle and 32-cycle prescaler periods is chosen so that the total period is exactly the programmed ratio.

The ratio is loaded through three byte-wide write strobes into a staging register. Only a write to the least significant byte arms a change. The armed value takes over at the end of the output period in progress, so that period is never shortened or stretched. Values under the minimum ratio of 2048 are raised by 2048 when they are committed. For a move to an adjacent channel, a single low-byte write is enough, because the upper bytes keep their staged contents.

Top module: `rf_pulse_swallow_div`

## Requirements
- R1: A synchronous active-high `rst` sets the active ratio and the staged ratio to 2048 and clears any armed change. The first output pulse comes in the 2048th clock after reset is released.
- R2: `div_out` is high for exactly one clock per period. The distance between two consecutive pulses equals the active ratio `ratio_o` that held during that period.
- R3: The active ratio splits into a swallow field A (bits 4..0) and a main field N (bits 17..5). Each period begins with ((32 − A) mod 32) prescaler cycles of 31 clocks, during which `mod_sel` is high, followed by 32-clock prescaler cycles with `mod_sel` low. `mod_sel` is therefore low in the pulse cycle and rises only in the clock after a pulse.
- R4: A write with `wr_en` high and `wr_sel` = 0 loads staged bits 7..0 from `wr_data`. `wr_sel` = 1 loads bits 15..8. `wr_sel` = 2 loads bits 17..16 from `wr_data[1:0]`. `wr_sel` = 3 changes nothing.
- R5: Writes with `wr_sel` = 1, 2 or 3 do not arm a change, so `ratio_o` stays as it is across any later boundary.
- R6: A write with `wr_sel` = 0 arms a change. `ratio_o` takes the staged value in the clock after the next pulse and holds it in every other clock.
- R7: When a staged value below 2048 is committed, it becomes that value plus 2048. `ratio_o` is never below 2048.
- R8: A low-byte write on its own commits a ratio whose bits 17..8 are the previously staged upper bytes.
- R9: A low-byte write given in the pulse cycle does not join the commit at that boundary. That boundary commits the value staged before the write, and the new value waits for the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Byte lane select: 0 low, 1 middle, 2 top bits, 3 unused |
| wr_data | input | 8 | Write data byte |
| div_out | output | 1 | Divided output, one clock wide per period |
| mod_sel | output | 1 | Prescaler modulus control, high while dividing by 31 |
| ratio_o | output | 18 | Ratio currently in effect |

## Verification
The bench targets ratios with a zero swallow field, a swallow field of one (31 short prescaler cycles, the most the design ever uses), and middle values. A wrong split or a wrong modulus mix shows up as a period that is off by up to 32 clocks, or as `mod_sel` high for the wrong span. It reprograms the ratio in the middle of a period and checks that the old period still ends on time; a design that commits at once would cut that period short. It writes a value below the minimum, which a design without folding would run as a very short period. It also places a low-byte write exactly in a pulse cycle, where a design that lets the write bypass the staging register would take the new value one boundary early.

// File: rtl/rf_pulse_swallow_div.sv
module rf_pulse_swallow_div #(
  parameter int SW_W      = 5,
  parameter int MN_W      = 13,
  parameter int MIN_RATIO = 2048
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [7:0]             wr_data,
  output logic                   div_out,
  output logic                   mod_sel,
  output logic [SW_W+MN_W-1:0]   ratio_o
);
  localparam int RW     = SW_W + MN_W;
  localparam int PRE    = 1 << SW_W;
  localparam int NB     = (RW + 7) / 8;
  localparam int MIN_A  = MIN_RATIO % PRE;
  localparam int RST_SC = (PRE - MIN_A) % PRE;
  localparam int RST_MC = (MIN_RATIO / PRE) + ((MIN_A != 0) ? 1 : 0);

  logic [RW-1:0]   shadow, active, folded, nxt;
  logic            pend;
  logic [SW_W-1:0] pc, sc, sc_dec, n_m, n_a;
  logic [MN_W:0]   mc, n_t;
  logic            last_pre;

  assign last_pre = (pc == '0);
  assign div_out  = last_pre && (mc == (MN_W+1)'(1));
  assign mod_sel  = (sc != '0);
  assign ratio_o  = active;

  assign folded = (shadow < RW'(MIN_RATIO)) ? shadow + RW'(MIN_RATIO) : shadow;
  assign nxt    = pend ? folded : active;
  assign n_a    = nxt[SW_W-1:0];
  assign n_m    = -n_a;
  assign n_t    = {1'b0, nxt[RW-1:SW_W]} + {{MN_W{1'b0}}, |n_a};
  assign sc_dec = mod_sel ? sc - 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= RW'(MIN_RATIO);
      shadow <= RW'(MIN_RATIO);
      pend   <= 1'b0;
      mc     <= (MN_W+1)'(RST_MC);
      sc     <= SW_W'(RST_SC);
      pc     <= (RST_SC != 0) ? SW_W'(PRE-2) : SW_W'(PRE-1);
    end else begin
      if (div_out) begin
        active <= nxt;
        pend   <= 1'b0;
        mc     <= n_t;
        sc     <= n_m;
        pc     <= (n_m != '0) ? SW_W'(PRE-2) : SW_W'(PRE-1);
      end else if (last_pre) begin
        mc <= mc - 1'b1;
        sc <= sc_dec;
        pc <= (sc_dec != '0) ? SW_W'(PRE-2) : SW_W'(PRE-1);
      end else begin
        pc <= pc - 1'b1;
      end
      if (wr_en) begin
        for (int b = 0; b < NB; b++) begin
          if (int'(wr_sel) == b) begin
            for (int i = 0; i < 8; i++) begin
              if (b*8 + i < RW) shadow[b*8 + i] <= wr_data[i];
            end
          end
        end
        if (wr_sel == 2'd0) pend <= 1'b1;
      end
    end
  end
endmodule

module swallow_div_props #(
  parameter int RW  = 18,
  parameter int MIN = 2048
) (
  input logic          clk,
  input logic          rst,
  input logic          div_out,
  input logic          mod_sel,
  input logic [RW-1:0] ratio_o
);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);
  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !div_out |=> $stable(ratio_o));
  assert_ratio_floor_R7: assert property (@(posedge clk) disable iff (rst)
    ratio_o >= RW'(MIN));
  assert_modsel_low_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    div_out |-> !mod_sel);
  assert_modsel_rise_at_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_sel) |-> $past(div_out));
endmodule

bind rf_pulse_swallow_div swallow_div_props #(.RW(SW_W+MN_W), .MIN(MIN_RATIO)) u_props (
  .clk(clk), .rst(rst), .div_out(div_out), .mod_sel(mod_sel), .ratio_o(ratio_o)
);

// File: tb/sim_rf_pulse_swallow_div.sv
`timescale 1ns/1ps
module sim_rf_pulse_swallow_div;
  logic clk = 1'b0;
  logic rst = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic div_out, mod_sel;
  logic [17:0] ratio_o;

  always #4 clk = ~clk;

  rf_pulse_swallow_div u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .div_out(div_out), .mod_sel(mod_sel), .ratio_o(ratio_o)
  );

  int total = 0, fails = 0;
  int m_act = 2048, m_sh = 2048, m_pos = 0, gap = 0;
  bit m_pend = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit r, input bit we, input logic [1:0] sel, input logic [7:0] d);
    int a, m;
    @(negedge clk);
    a = m_act % 32;
    m = (32 - a) % 32;
    check(div_out == (m_pos == m_act - 1), "R2 div_out", int'(div_out), int'(m_pos == m_act - 1));
    check(mod_sel == (m_pos < 31 * m), "R3 mod_sel", int'(mod_sel), int'(m_pos < 31 * m));
    check(int'(ratio_o) == m_act, "R6 ratio_o", int'(ratio_o), m_act);
    if (!r && div_out) begin
      check(gap + 1 == m_act, "R2 period", gap + 1, m_act);
      gap = 0;
    end else if (r) gap = 0;
    else gap++;
    rst = r; wr_en = we; wr_sel = sel; wr_data = d;
    if (r) begin
      m_act = 2048; m_sh = 2048; m_pend = 0; m_pos = 0;
    end else begin
      if (m_pos == m_act - 1) begin
        m_pos = 0;
        if (m_pend) begin
          m_act = (m_sh < 2048) ? m_sh + 2048 : m_sh;
          m_pend = 0;
        end
      end else m_pos++;
      if (we) begin
        case (sel)
          2'd0: begin m_sh = (m_sh & 32'h3FF00) | int'(d); m_pend = 1; end
          2'd1: m_sh = (m_sh & 32'h300FF) | (int'(d) << 8);
          2'd2: m_sh = (m_sh & 32'h0FFFF) | ((int'(d) & 3) << 16);
          default: ;
        endcase
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 2'd0, 8'd0);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    tick(0, 1, sel, d);
  endtask

  task automatic past_boundary();
    while (m_pos != m_act - 1) idle(1);
    idle(2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) tick(1, 0, 2'd0, 8'd0);
    @(negedge clk);
    check(ratio_o == 18'd2048 && !div_out, "R1 reset ratio", int'(ratio_o), 2048);
    idle(2100);
    check(gap == 2100 - 2048, "R1 first pulse", gap, 2100 - 2048);

    idle(300);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h0B);
    past_boundary();
    check(ratio_o == 18'd2048, "R5 upper bytes do not arm", int'(ratio_o), 2048);
    idle(500);
    wr(2'd0, 8'hB8);
    check(m_pos != 0, "R6 write mid-period", m_pos, 1);
    past_boundary();
    check(ratio_o == 18'd3000, "R4 byte lanes", int'(ratio_o), 3000);
    past_boundary();

    idle(700);
    wr(2'd0, 8'hB9);
    past_boundary();
    check(ratio_o == 18'd3001, "R8 low byte only", int'(ratio_o), 3001);
    past_boundary();

    wr(2'd1, 8'h00);
    wr(2'd0, 8'd100);
    past_boundary();
    check(ratio_o == 18'd2148, "R7 fold", int'(ratio_o), 2148);

    wr(2'd3, 8'hFF);
    past_boundary();
    check(ratio_o == 18'd2148, "R4 lane 3 ignored", int'(ratio_o), 2148);
    wr(2'd0, 8'd1);
    past_boundary();
    check(ratio_o == 18'd2049, "R4 lane 3 left staging intact", int'(ratio_o), 2049);
    past_boundary();

    wr(2'd1, 8'h0A);
    wr(2'd0, 8'h00);
    while (m_pos != m_act - 1) idle(1);
    wr(2'd0, 8'h20);
    idle(1);
    check(ratio_o == 18'd2560, "R9 pulse-cycle write waits", int'(ratio_o), 2560);
    past_boundary();
    check(ratio_o == 18'd2592, "R9 following boundary", int'(ratio_o), 2592);
    past_boundary();

    summary();
    $finish;
  end
endmodule